// File: doc/BRIEF.md
# Privileged Address Translation Probe Unit

This block carries out a privileged probe that turns a 64-bit virtual address into a physical address without touching memory. A request brings the source operand, that operand's deferred-exception tag, the qualifying predicate and four status inputs: current privilege level, data-translation enable, interruption-collection enable and virtual-machine mode. The block reports either the physical address to be written to the destination, with a cleared deferred-exception tag, or a single fault code with interruption-status bits.

The three upper address bits pick one of eight region registers. The region identifier held there, together with the virtual page number, is matched against a small fully associative data TLB that software fills through an insert port. Pages are a fixed 4 KiB. When data translation is enabled and the TLB cannot supply a present translation, the block asks an external page-table walker over a request/response port and waits for its answer. Requests arriving while the walker is outstanding are ignored.

Top module: `xlat_probe`

## Requirements
- R1: A request with the qualifying predicate low produces a `done` pulse one cycle later with `res_wr` low and `fault_valid` low.
- R2: With `vm_mode` high the fault code is 1 (virtualization), whatever the privilege level or operand tag.
- R3: With `vm_mode` low and `cpl` not 0 the fault code is 2 (privileged operation), whatever the operand tag and TLB contents.
- R4: With a legal privilege level and `src_tag` high the fault code is 3 (register consumption) and no walker request is issued.
- R5: On a TLB hit on a present entry the result arrives one cycle after the request with `res_wr` high, `res_paddr` equal to the entry's physical page number above address bits 11:0 of the source, and `res_nat` low.
- R6: The match uses the region identifier held in the region register selected by source bits 63:61; changing that register makes a previously hitting address miss.
- R7: With `xlat_en` low, a miss or a not-present hit never reaches the walker and gives fault code 6 (alternate data TLB) when `intr_coll` is 1 and 7 (nested data TLB) when it is 0.
- R8: With `xlat_en` high, a miss or a not-present hit raises `walk_req` with the region identifier and page number, held with `busy` high until `walk_rsp_valid`; requests in that time are ignored.
- R9: One cycle after the walker responds the block reports fault code 4 (data TLB) on a walker miss, 5 (page not present) on a walker hit with present low, and otherwise the walker's page number above the source offset.
- R10: Every fault sets `isr_na` and leaves `isr_r`, `isr_w` and `res_wr` low.
- R11: Inserts fill TLB slots in round-robin order starting at slot 0, so the ninth insert after reset replaces the first.
- R12: An insert in the same cycle as a request is not seen by that request; it is seen from the next request on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Probe request strobe |
| req_pred | input | 1 | Qualifying predicate |
| src_addr | input | 64 | Virtual address operand |
| src_tag | input | 1 | Deferred-exception tag of the operand |
| cpl | input | 2 | Current privilege level |
| xlat_en | input | 1 | Data translation enable |
| intr_coll | input | 1 | Interruption collection enable |
| vm_mode | input | 1 | Virtual-machine mode |
| rgn_wr_en | input | 1 | Region register write strobe |
| rgn_wr_idx | input | 3 | Region register index |
| rgn_wr_rid | input | 24 | Region identifier to write |
| ins_en | input | 1 | TLB insert strobe |
| ins_present | input | 1 | Present bit of inserted entry |
| ins_rid | input | 24 | Region identifier of inserted entry |
| ins_vpn | input | 52 | Virtual page number of inserted entry |
| ins_ppn | input | 38 | Physical page number of inserted entry |
| walk_req | output | 1 | Walker request, held until response |
| walk_rid | output | 24 | Region identifier for the walker |
| walk_vpn | output | 52 | Virtual page number for the walker |
| walk_rsp_valid | input | 1 | Walker response strobe |
| walk_rsp_hit | input | 1 | Walker found an entry |
| walk_rsp_present | input | 1 | Walker entry is present |
| walk_rsp_ppn | input | 38 | Walker physical page number |
| busy | output | 1 | Walk outstanding, requests ignored |
| done | output | 1 | Operation completed this cycle |
| res_wr | output | 1 | Destination register write |
| res_paddr | output | 50 | Physical address result |
| res_nat | output | 1 | Deferred-exception tag of the result |
| fault_valid | output | 1 | A fault is reported |
| fault_code | output | 3 | Fault code (1..7 as in the requirements) |
| isr_na | output | 1 | Interruption status: non-access |
| isr_r | output | 1 | Interruption status: read |
| isr_w | output | 1 | Interruption status: write |

## Verification
A TLB insert and a probe lookup can land on the same clock edge, and so can a region-register write and a lookup. The bench drives an insert for exactly the address being probed in the request cycle and expects a translation-disabled miss (alternate fault) for that request, then a hit on a second probe. It also rewrites the region register of an address that hit earlier and expects the next probe of it to miss.

// File: rtl/probe_pkg.sv
package probe_pkg;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_VIRT    = 3'd1,
    FLT_PRIV    = 3'd2,
    FLT_NATCON  = 3'd3,
    FLT_DTLB    = 3'd4,
    FLT_NOTPRES = 3'd5,
    FLT_ALTDTLB = 3'd6,
    FLT_NESTED  = 3'd7
  } fault_e;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } probe_state_e;

endpackage

// File: rtl/probe_regions.sv
module probe_regions #(
  parameter int REG_CNT = 8,
  parameter int RID_W   = 24,
  localparam int IDX_W  = $clog2(REG_CNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [RID_W-1:0] wr_rid,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [RID_W-1:0] rd_rid
);

  logic [RID_W-1:0] rid_q [REG_CNT];

  for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rid_q[g] <= '0;
      else if (sel) rid_q[g] <= wr_rid;
    end
  end

  assign rd_rid = rid_q[rd_idx];

endmodule

// File: rtl/probe_tlb.sv
module probe_tlb #(
  parameter int ENTRIES = 8,
  parameter int RID_W   = 24,
  parameter int VPN_W   = 52,
  parameter int PPN_W   = 38,
  localparam int PTR_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_en,
  input  logic             ins_present,
  input  logic [RID_W-1:0] ins_rid,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic [PPN_W-1:0] ins_ppn,
  input  logic [RID_W-1:0] lk_rid,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic             lk_present,
  output logic [PPN_W-1:0] lk_ppn
);

  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] present_q;
  logic [RID_W-1:0]   rid_q [ENTRIES];
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [PTR_W-1:0]   ptr_q, ptr_d;

  // round-robin victim pointer
  always_comb begin
    ptr_d = ptr_q;
    if (ins_en) begin
      if (ptr_q == PTR_W'(ENTRIES - 1)) ptr_d = '0;
      else                              ptr_d = ptr_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic sel;
    assign sel = ins_en && (ptr_q == PTR_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g]   <= 1'b0;
        present_q[g] <= 1'b0;
      end else if (sel) begin
        valid_q[g]   <= 1'b1;
        present_q[g] <= ins_present;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        rid_q[g] <= ins_rid;
        vpn_q[g] <= ins_vpn;
        ppn_q[g] <= ins_ppn;
      end
    end
  end

  // associative match, lowest slot wins
  always_comb begin
    lk_hit     = 1'b0;
    lk_present = 1'b0;
    lk_ppn     = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (valid_q[i] && (rid_q[i] == lk_rid) && (vpn_q[i] == lk_vpn)) begin
        lk_hit     = 1'b1;
        lk_present = present_q[i];
        lk_ppn     = ppn_q[i];
      end
    end
  end

  // R11: an insert lands in the slot the pointer held
  a_r11_slot_filled: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |=> valid_q[$past(ptr_q)]);

endmodule

// File: rtl/probe_ctrl.sv
module probe_ctrl
  import probe_pkg::*;
#(
  parameter int VA_W  = 64,
  parameter int PG_W  = 12,
  parameter int RID_W = 24,
  parameter int PPN_W = 38,
  localparam int VPN_W = VA_W - PG_W,
  localparam int PA_W  = PPN_W + PG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_pred,
  input  logic [VA_W-1:0]  src_addr,
  input  logic             src_tag,
  input  logic [1:0]       cpl,
  input  logic             xlat_en,
  input  logic             intr_coll,
  input  logic             vm_mode,
  input  logic [RID_W-1:0] cur_rid,
  input  logic             tlb_hit,
  input  logic             tlb_present,
  input  logic [PPN_W-1:0] tlb_ppn,
  input  logic             walk_rsp_valid,
  input  logic             walk_rsp_hit,
  input  logic             walk_rsp_present,
  input  logic [PPN_W-1:0] walk_rsp_ppn,
  output logic             walk_req,
  output logic [RID_W-1:0] walk_rid,
  output logic [VPN_W-1:0] walk_vpn,
  output logic             busy,
  output logic             done,
  output logic             res_wr,
  output logic [PA_W-1:0]  res_paddr,
  output logic             fault_valid,
  output fault_e           fault_code,
  output logic             isr_na
);

  probe_state_e     state_q, state_d;
  logic             done_q, done_d;
  logic             wr_q, wr_d;
  fault_e           flt_q, flt_d;
  logic             na_q;
  logic [PA_W-1:0]  pa_q, pa_d;
  logic [RID_W-1:0] wrid_q;
  logic [VPN_W-1:0] wvpn_q;
  logic [PG_W-1:0]  off_q;
  logic             accept, capture;

  assign accept = req_valid && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    wr_d    = 1'b0;
    flt_d   = FLT_NONE;
    pa_d    = pa_q;
    capture = 1'b0;
    if (accept) begin
      done_d = 1'b1;
      if (!req_pred) begin
        done_d = 1'b1;
      end else if (vm_mode) begin
        flt_d = FLT_VIRT;
      end else if (cpl != 2'd0) begin
        flt_d = FLT_PRIV;
      end else if (src_tag) begin
        flt_d = FLT_NATCON;
      end else if (tlb_hit && tlb_present) begin
        wr_d = 1'b1;
        pa_d = {tlb_ppn, src_addr[PG_W-1:0]};
      end else if (xlat_en) begin
        done_d  = 1'b0;
        capture = 1'b1;
        state_d = ST_WALK;
      end else if (intr_coll) begin
        flt_d = FLT_ALTDTLB;
      end else begin
        flt_d = FLT_NESTED;
      end
    end else if ((state_q == ST_WALK) && walk_rsp_valid) begin
      state_d = ST_IDLE;
      done_d  = 1'b1;
      if (!walk_rsp_hit) begin
        flt_d = FLT_DTLB;
      end else if (!walk_rsp_present) begin
        flt_d = FLT_NOTPRES;
      end else begin
        wr_d = 1'b1;
        pa_d = {walk_rsp_ppn, off_q};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      wr_q    <= 1'b0;
      flt_q   <= FLT_NONE;
      na_q    <= 1'b0;
      pa_q    <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      wr_q    <= wr_d;
      flt_q   <= flt_d;
      na_q    <= (flt_d != FLT_NONE);
      pa_q    <= pa_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrid_q <= '0;
      wvpn_q <= '0;
      off_q  <= '0;
    end else if (capture) begin
      wrid_q <= cur_rid;
      wvpn_q <= src_addr[VA_W-1:PG_W];
      off_q  <= src_addr[PG_W-1:0];
    end
  end

  assign walk_req    = (state_q == ST_WALK);
  assign busy        = (state_q == ST_WALK);
  assign walk_rid    = wrid_q;
  assign walk_vpn    = wvpn_q;
  assign done        = done_q;
  assign res_wr      = wr_q;
  assign res_paddr   = pa_q;
  assign fault_code  = flt_q;
  assign fault_valid = (flt_q != FLT_NONE);
  assign isr_na      = na_q;

  a_r1_pred_off_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !req_pred) |=> (done && !res_wr && !fault_valid));

  a_r4_tag_no_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_pred && !vm_mode && (cpl == 2'd0) && src_tag)
      |=> (!walk_req && (fault_code == FLT_NATCON)));

  a_r8_walk_held: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && !walk_rsp_valid) |=> (walk_req && $stable(walk_vpn) && $stable(walk_rid)));

  a_r10_fault_status: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> (isr_na && done && !res_wr));

  a_r9_walk_finishes: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && walk_rsp_valid) |=> (done && !walk_req));

endmodule

// File: rtl/xlat_probe.sv
module xlat_probe #(
  parameter int VA_W    = 64,
  parameter int PG_W    = 12,
  parameter int PPN_W   = 38,
  parameter int RID_W   = 24,
  parameter int ENTRIES = 8,
  parameter int REG_CNT = 8,
  localparam int VPN_W  = VA_W - PG_W,
  localparam int PA_W   = PPN_W + PG_W,
  localparam int RIDX_W = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_pred,
  input  logic [VA_W-1:0]   src_addr,
  input  logic              src_tag,
  input  logic [1:0]        cpl,
  input  logic              xlat_en,
  input  logic              intr_coll,
  input  logic              vm_mode,
  input  logic              rgn_wr_en,
  input  logic [RIDX_W-1:0] rgn_wr_idx,
  input  logic [RID_W-1:0]  rgn_wr_rid,
  input  logic              ins_en,
  input  logic              ins_present,
  input  logic [RID_W-1:0]  ins_rid,
  input  logic [VPN_W-1:0]  ins_vpn,
  input  logic [PPN_W-1:0]  ins_ppn,
  output logic              walk_req,
  output logic [RID_W-1:0]  walk_rid,
  output logic [VPN_W-1:0]  walk_vpn,
  input  logic              walk_rsp_valid,
  input  logic              walk_rsp_hit,
  input  logic              walk_rsp_present,
  input  logic [PPN_W-1:0]  walk_rsp_ppn,
  output logic              busy,
  output logic              done,
  output logic              res_wr,
  output logic [PA_W-1:0]   res_paddr,
  output logic              res_nat,
  output logic              fault_valid,
  output logic [2:0]        fault_code,
  output logic              isr_na,
  output logic              isr_r,
  output logic              isr_w
);

  logic [RID_W-1:0] cur_rid;
  logic             tlb_hit, tlb_present;
  logic [PPN_W-1:0] tlb_ppn;
  probe_pkg::fault_e flt;

  probe_regions #(.REG_CNT(REG_CNT), .RID_W(RID_W)) u_rgn (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (rgn_wr_en),
    .wr_idx (rgn_wr_idx),
    .wr_rid (rgn_wr_rid),
    .rd_idx (src_addr[VA_W-1 -: RIDX_W]),
    .rd_rid (cur_rid)
  );

  probe_tlb #(.ENTRIES(ENTRIES), .RID_W(RID_W), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_tlb (
    .clk         (clk),
    .rst_n       (rst_n),
    .ins_en      (ins_en),
    .ins_present (ins_present),
    .ins_rid     (ins_rid),
    .ins_vpn     (ins_vpn),
    .ins_ppn     (ins_ppn),
    .lk_rid      (cur_rid),
    .lk_vpn      (src_addr[VA_W-1:PG_W]),
    .lk_hit      (tlb_hit),
    .lk_present  (tlb_present),
    .lk_ppn      (tlb_ppn)
  );

  probe_ctrl #(.VA_W(VA_W), .PG_W(PG_W), .RID_W(RID_W), .PPN_W(PPN_W)) u_ctrl (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_valid        (req_valid),
    .req_pred         (req_pred),
    .src_addr         (src_addr),
    .src_tag          (src_tag),
    .cpl              (cpl),
    .xlat_en          (xlat_en),
    .intr_coll        (intr_coll),
    .vm_mode          (vm_mode),
    .cur_rid          (cur_rid),
    .tlb_hit          (tlb_hit),
    .tlb_present      (tlb_present),
    .tlb_ppn          (tlb_ppn),
    .walk_rsp_valid   (walk_rsp_valid),
    .walk_rsp_hit     (walk_rsp_hit),
    .walk_rsp_present (walk_rsp_present),
    .walk_rsp_ppn     (walk_rsp_ppn),
    .walk_req         (walk_req),
    .walk_rid         (walk_rid),
    .walk_vpn         (walk_vpn),
    .busy             (busy),
    .done             (done),
    .res_wr           (res_wr),
    .res_paddr        (res_paddr),
    .fault_valid      (fault_valid),
    .fault_code       (flt),
    .isr_na           (isr_na)
  );

  assign fault_code = flt;
  assign res_nat    = 1'b0;   // R5: translated result always carries a clear tag
  assign isr_r      = 1'b0;   // R10: probe is never a read
  assign isr_w      = 1'b0;   // R10: probe is never a write

  a_r5_write_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    res_wr |-> (done && !fault_valid && !res_nat));

endmodule

// File: tb/xlat_probe_test.sv
`timescale 1ns/1ps
module xlat_probe_test;

  localparam int F_VIRT = 1, F_PRIV = 2, F_NAT = 3, F_DTLB = 4,
                 F_NP = 5, F_ALT = 6, F_NEST = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_pred, src_tag, xlat_en, intr_coll, vm_mode;
  logic [63:0] src_addr;
  logic [1:0]  cpl;
  logic        rgn_wr_en;
  logic [2:0]  rgn_wr_idx;
  logic [23:0] rgn_wr_rid;
  logic        ins_en, ins_present;
  logic [23:0] ins_rid;
  logic [51:0] ins_vpn;
  logic [37:0] ins_ppn;
  logic        walk_req;
  logic [23:0] walk_rid;
  logic [51:0] walk_vpn;
  logic        walk_rsp_valid, walk_rsp_hit, walk_rsp_present;
  logic [37:0] walk_rsp_ppn;
  logic        busy, done, res_wr, res_nat, fault_valid, isr_na, isr_r, isr_w;
  logic [49:0] res_paddr;
  logic [2:0]  fault_code;

  int n_chk = 0;
  int n_err = 0;
  int n_ins = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  xlat_probe uut (.*);

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  task automatic set_rgn(input logic [2:0] idx, input logic [23:0] rid);
    @(negedge clk);
    rgn_wr_en = 1'b1; rgn_wr_idx = idx; rgn_wr_rid = rid;
    @(negedge clk);
    rgn_wr_en = 1'b0;
  endtask

  task automatic drive_ins(input logic p, input logic [23:0] rid,
                           input logic [51:0] vpn, input logic [37:0] ppn);
    ins_en = 1'b1; ins_present = p; ins_rid = rid; ins_vpn = vpn; ins_ppn = ppn;
    n_ins++;
  endtask

  task automatic insert(input logic p, input logic [23:0] rid,
                        input logic [51:0] vpn, input logic [37:0] ppn);
    @(negedge clk);
    drive_ins(p, rid, vpn, ppn);
    @(negedge clk);
    ins_en = 1'b0;
  endtask

  task automatic drive_req(input logic [63:0] va, input logic tag, input logic [1:0] pl,
                           input logic vm, input logic dt, input logic ic, input logic pr);
    req_valid = 1'b1; src_addr = va; src_tag = tag; cpl = pl;
    vm_mode = vm; xlat_en = dt; intr_coll = ic; req_pred = pr;
  endtask

  // one request cycle; returns at the negedge where the result is visible
  task automatic probe(input logic [63:0] va, input logic tag, input logic [1:0] pl,
                       input logic vm, input logic dt, input logic ic, input logic pr);
    @(negedge clk);
    drive_req(va, tag, pl, vm, dt, ic, pr);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_fault(input string rq, input int code);
    chk({rq, " done"}, 64'(done), 64'd1);
    chk({rq, " fault_valid"}, 64'(fault_valid), 64'd1);
    chk({rq, " fault_code"}, 64'(fault_code), 64'(code));
    chk({rq, " R10 isr"}, {61'd0, isr_na, isr_r, isr_w}, 64'b100);
    chk({rq, " R10 no write"}, 64'(res_wr), 64'd0);
  endtask

  task automatic expect_pa(input string rq, input logic [49:0] pa);
    chk({rq, " done"}, 64'(done), 64'd1);
    chk({rq, " res_wr"}, 64'(res_wr), 64'd1);
    chk({rq, " fault_valid"}, 64'(fault_valid), 64'd0);
    chk({rq, " res_paddr"}, 64'(res_paddr), 64'(pa));
    chk({rq, " res_nat"}, 64'(res_nat), 64'd0);
  endtask

  localparam logic [63:0] VA_A = 64'h0000_0000_1234_5ABC;
  localparam logic [63:0] VA_B = 64'hA000_0000_0777_7123;   // region 5
  localparam logic [63:0] VA_C = 64'h0000_0000_0999_9F00;   // region 0
  localparam logic [63:0] VA_D = 64'hC000_0000_0000_3456;   // region 6, never inserted
  localparam logic [37:0] PPN_A = 38'h00_0ABC_DE;
  localparam logic [37:0] PPN_C = 38'h01_2345_67;
  localparam logic [37:0] PPN_W1 = 38'h3F_0000_11;

  task automatic t_reset();
    chk("R1 reset done", 64'(done), 64'd0);
    chk("R10 reset fault", 64'(fault_valid), 64'd0);
    chk("R8 reset walk_req", 64'(walk_req), 64'd0);
    chk("R8 reset busy", 64'(busy), 64'd0);
  endtask

  task automatic t_setup();
    set_rgn(3'd0, 24'h000011);
    set_rgn(3'd5, 24'h000055);
    set_rgn(3'd6, 24'h000066);
    insert(1'b1, 24'h000011, VA_A[63:12], PPN_A);        // slot 0
    insert(1'b0, 24'h000055, VA_B[63:12], 38'h1);        // slot 1, not present
  endtask

  task automatic t_r1_pred_off();
    probe(VA_A, 1'b1, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0);
    chk("R1 done", 64'(done), 64'd1);
    chk("R1 no write", 64'(res_wr), 64'd0);
    chk("R1 no fault", 64'(fault_valid), 64'd0);
  endtask

  task automatic t_priority();
    probe(VA_A, 1'b1, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1);
    expect_fault("R2 virtualization first", F_VIRT);
    probe(VA_A, 1'b1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1);
    expect_fault("R3 privilege before tag", F_PRIV);
    probe(VA_A, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1);
    expect_fault("R3 privilege before hit", F_PRIV);
    probe(VA_D, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1);
    expect_fault("R4 tag consumption", F_NAT);
    chk("R4 no walker request", 64'(walk_req), 64'd0);
  endtask

  task automatic t_r5_hit();
    probe(VA_A, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    expect_pa("R5 hit dt=0", {PPN_A, VA_A[11:0]});
    probe(VA_A | 64'hFFF, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1);
    expect_pa("R5 hit dt=1 offset", {PPN_A, 12'hFFF});
  endtask

  task automatic t_r7_disabled();
    probe(VA_D, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1);
    expect_fault("R7 miss ic=1", F_ALT);
    chk("R7 no walk", 64'(walk_req), 64'd0);
    probe(VA_D, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    expect_fault("R7 miss ic=0", F_NEST);
    probe(VA_B, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1);
    expect_fault("R7 not-present ic=1", F_ALT);
  endtask

  task automatic walk_reply(input logic h, input logic p, input logic [37:0] ppn);
    walk_rsp_valid = 1'b1; walk_rsp_hit = h; walk_rsp_present = p; walk_rsp_ppn = ppn;
    @(negedge clk);
    walk_rsp_valid = 1'b0;
  endtask

  task automatic t_walker();
    // not-present TLB entry goes to walker
    probe(VA_B, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R8 walk_req", 64'(walk_req), 64'd1);
    chk("R8 busy", 64'(busy), 64'd1);
    chk("R8 walk_rid", 64'(walk_rid), 64'h55);
    chk("R8 walk_vpn", 64'(walk_vpn), 64'(VA_B[63:12]));
    chk("R8 no early done", 64'(done), 64'd0);
    // request while busy is ignored
    drive_req(VA_A, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 busy request ignored", 64'(done), 64'd0);
    chk("R8 still waiting", 64'(walk_req), 64'd1);
    walk_reply(1'b1, 1'b1, PPN_W1);
    expect_pa("R9 walker hit", {PPN_W1, VA_B[11:0]});
    chk("R9 walk released", 64'(walk_req), 64'd0);
    // walker miss
    probe(VA_D, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R8 miss walk_req", 64'(walk_req), 64'd1);
    walk_reply(1'b0, 1'b0, 38'h0);
    expect_fault("R9 walker miss", F_DTLB);
    // walker not present
    probe(VA_D, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1);
    walk_reply(1'b1, 1'b0, 38'h5);
    expect_fault("R9 walker not present", F_NP);
  endtask

  task automatic t_r12_same_cycle();
    @(negedge clk);
    drive_req(VA_C, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1);
    drive_ins(1'b1, 24'h000011, VA_C[63:12], PPN_C);
    @(negedge clk);
    req_valid = 1'b0; ins_en = 1'b0;
    expect_fault("R12 insert not seen", F_ALT);
    probe(VA_C, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1);
    expect_pa("R12 insert seen next", {PPN_C, VA_C[11:0]});
  endtask

  task automatic t_r11_round_robin();
    int fill;
    fill = 8 - (n_ins % 8);
    for (int i = 0; i < fill; i++)
      insert(1'b1, 24'h000066, 52'hC000_0000_1000_0 + 52'(i), 38'(i + 100));
    probe(VA_A, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    expect_pa("R11 first slot kept", {PPN_A, VA_A[11:0]});
    insert(1'b1, 24'h000066, 52'hC000_0000_2000_0, 38'h77);
    probe(VA_A, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    expect_fault("R11 first slot replaced", F_NEST);
  endtask

  task automatic t_r6_region();
    insert(1'b1, 24'h000011, VA_A[63:12], PPN_A);
    probe(VA_A, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1);
    expect_pa("R6 hit with region id", {PPN_A, VA_A[11:0]});
    set_rgn(3'd0, 24'h000022);
    probe(VA_A, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1);
    expect_fault("R6 region id changed", F_ALT);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_pred = 0; src_addr = '0; src_tag = 0; cpl = '0;
    xlat_en = 0; intr_coll = 0; vm_mode = 0;
    rgn_wr_en = 0; rgn_wr_idx = '0; rgn_wr_rid = '0;
    ins_en = 0; ins_present = 0; ins_rid = '0; ins_vpn = '0; ins_ppn = '0;
    walk_rsp_valid = 0; walk_rsp_hit = 0; walk_rsp_present = 0; walk_rsp_ppn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_setup();
    t_r1_pred_off();
    t_priority();
    t_r5_hit();
    t_r7_disabled();
    t_walker();
    t_r12_same_cycle();
    t_r11_round_robin();
    t_r6_region();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

endmodule